// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write Memory

This block is an on-chip memory that behaves like a pipelined synchronous static RAM. Address, write data, chip enables and the write controls are all captured on the rising clock edge. A read delivers its word through an output register two edges after the address was captured. A write can update any subset of its 9-bit byte lanes. Each lane holds 8 data bits plus one parity bit, and each lane is stored on its own.

`LANES` sets the word width: four lanes give 36 bits and two lanes give 18 bits. `ADDR_W` sets the depth, which is kept small. A global write input forces every lane to be written. Otherwise a byte-write gate must be active before the per-lane enables take effect. Three chip enables of mixed polarity let several devices share one bus with no wait state between them. A deselect travels down the same two-stage pipeline as a read, so a read issued just before a deselect still returns its data. The output enable acts combinationally on the output drive.

Each request moves through three stages:

- **Stage 0 (input register).** Holds an operation code: `OP_IDLE`, `OP_READ` or `OP_WRITE`.
- **Stage 1.** Writes commit to the lane banks, and reads fetch the word.
- **Output stage.** A two-state machine:
  - `ST_QUIET` goes to `ST_DRIVE` when stage 1 holds `OP_READ`.
  - `ST_DRIVE` goes back to `ST_QUIET` when stage 1 holds `OP_IDLE` or `OP_WRITE`.
  - Each state stays put on the same conditions: `ST_DRIVE` on a further read, `ST_QUIET` on a further idle or write.

Top module: `sram_pipe_top`

## Requirements
- R1: The address of a read is captured at edge N. After edge N+2 the word is on `q`, and `q_drv` is 1 while `oe_n` is low.
- R2: With the chip selected and `gw_n` low, all lanes of the addressed word are written from `din`, whatever `bwe_n` and `bw_n` say.
- R3: With `gw_n` high and `bwe_n` low, lane i is written exactly when `bw_n[i]` is low. Lane i occupies bits `[9*i+8 : 9*i]`, so lane a is bits 8:0. The other lanes keep their old contents. If no lane is enabled, the cycle is a read.
- R4: With `gw_n` and `bwe_n` both high, no lane is written and the selected cycle is a read, even if `bw_n` bits are low.
- R5: With `LANES` = 2 the word is 18 bits wide, with two lane enables, and the lane rules of R2 and R3 hold unchanged.
- R6: `oe_n` high forces `q_drv` to 0 and `q` to zero in the same cycle, with no clock edge needed. Lowering it again restores the registered word.
- R7: The chip is selected only when `ce_n` = 0, `ce2` = 1 and `ce2_n` = 0. Any other combination neither writes nor drives a read.
- R8: A deselect captured at edge N turns `q_drv` off after edge N+2. A read captured at edge N-1 is still driven after edge N+1.
- R9: The output slot of a write cycle (after edge N+2 for a write captured at edge N) has `q_drv` at 0.
- R10: A read in the cycle right after a write to the same address returns the newly written data, with no wait cycle.
- R11: While `rst_n` is low and after its release, `q_drv` stays 0 until a read completes.
- R12: All 9 bits of each lane, including the parity bit 8, are stored and returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline control |
| addr | input | ADDR_W | Word address |
| din | input | 9*LANES | Write data, lane i at bits 9*i+8:9*i |
| ce_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high depth-expansion enable |
| ce2_n | input | 1 | Active-low depth-expansion enable |
| gw_n | input | 1 | Active-low global write, all lanes |
| bwe_n | input | 1 | Active-low gate for the per-lane enables |
| bw_n | input | LANES | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| q | output | 9*LANES | Read data, zero when not driven |
| q_drv | output | 1 | Output drive enable for the data pins |

## Verification
The assertions check on every cycle the captured write mask under a global write or a gated byte write, and that a gated-off byte write becomes a read. They also check that a bad enable combination yields an idle stage, and that the drive enable two cycles on follows the operation captured earlier, including the quiet state during reset. Only the bench's scenarios can show the stored contents. That covers merged lanes, the parity bit, read-after-write, and the narrow build against a reference array. Combinational output-enable toggling within a single cycle is also left to the scenarios.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_DRIVE = 1'b1
    } out_st_e;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg
    import sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      din,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [W-1:0]      din_q,
    output logic [LANES-1:0]  mask_q
);
    logic             sel_c;
    logic [LANES-1:0] mask_c;
    op_e              op_c;

    // Decode of the sampled controls into an operation and a lane mask
    always_comb begin
        sel_c = !ce_n && ce2 && !ce2_n;
        if (!gw_n) begin
            mask_c = '1;
        end else if (!bwe_n) begin
            mask_c = ~bw_n;
        end else begin
            mask_c = '0;
        end
        if (!sel_c) begin
            op_c = OP_IDLE;
        end else if (|mask_c) begin
            op_c = OP_WRITE;
        end else begin
            op_c = OP_READ;
        end
    end

    // Stage-0 operation register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= op_c;
        end
    end

    always_ff @(posedge clk) begin
        addr_q <= addr;
        din_q  <= din;
        mask_q <= mask_c;
    end

    a_r2_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce2 && !ce2_n && !gw_n) |=> (op_q == OP_WRITE && (&mask_q)));

    a_r3_lane_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce2 && !ce2_n && gw_n && !bwe_n) |=> (mask_q == ~$past(bw_n)));

    a_r4_gate_off_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce2 && !ce2_n && gw_n && bwe_n) |=> (op_q == OP_READ));

    a_r7_bad_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce2 || ce2_n) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int ADDR_W = 5,
    parameter int LW     = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LW-1:0]     wdata,
    output logic [LW-1:0]     rdata
);
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            rdata <= cells[addr];
        end
    end
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe
    import sram_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_e          op_in,
    input  logic [W-1:0] rdata,
    input  logic         oe_n,
    output logic [W-1:0] q,
    output logic         q_drv
);
    op_e          op_s1;
    out_st_e      st;
    out_st_e      st_nxt;
    logic [W-1:0] q_reg;

    // State register of the output stage, and the stage-1 operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_s1 <= OP_IDLE;
            st    <= ST_QUIET;
        end else begin
            op_s1 <= op_in;
            st    <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (op_s1 == OP_READ) begin
            q_reg <= rdata;
        end
    end

    always_comb begin
        unique case (op_s1)
            OP_READ:           st_nxt = ST_DRIVE;
            OP_IDLE, OP_WRITE: st_nxt = ST_QUIET;
            default:           st_nxt = ST_QUIET;
        endcase
    end

    // Output process: asynchronous output enable gates the drive
    always_comb begin
        q_drv = (st == ST_DRIVE) && !oe_n;
        q     = q_drv ? q_reg : '0;
    end

    a_r1_read_reaches_output: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_in, 2) == OP_READ) |-> (q_drv || oe_n));

    a_r8_deselect_two_late: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_in, 2) != OP_READ) |-> !q_drv);

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            a_r11_quiet_in_reset: assert (!q_drv);
        end
    end
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
    import sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      din,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    output logic [W-1:0]      q,
    output logic              q_drv
);
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      din_q;
    logic [LANES-1:0]  mask_q;
    logic [W-1:0]      rd_word;

    sram_in_reg #(.LANES(LANES), .ADDR_W(ADDR_W)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .din    (din),
        .ce_n   (ce_n),
        .ce2    (ce2),
        .ce2_n  (ce2_n),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .op_q   (op_q),
        .addr_q (addr_q),
        .din_q  (din_q),
        .mask_q (mask_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_lane_bank #(.ADDR_W(ADDR_W), .LW(LANE_W)) u_bank (
            .clk   (clk),
            .we    ((op_q == OP_WRITE) && mask_q[i]),
            .re    (op_q == OP_READ),
            .addr  (addr_q),
            .wdata (din_q[i*LANE_W +: LANE_W]),
            .rdata (rd_word[i*LANE_W +: LANE_W])
        );
    end

    sram_out_pipe #(.W(W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .op_in (op_q),
        .rdata (rd_word),
        .oe_n  (oe_n),
        .q     (q),
        .q_drv (q_drv)
    );
endmodule

// File: tb/tb_sram_pipe_top.sv
module tb_sram_pipe_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [4:0]  adr;
    logic [35:0] din;
    logic        ce_n, ce2, ce2_n, gw_n, bwe_n, oe_n;
    logic [3:0]  bw_n;
    logic [35:0] q;
    logic        q_drv;

    logic [4:0]  adr_n;
    logic [17:0] din_n;
    logic        ce_nn, gw_nn, bwe_nn;
    logic [1:0]  bw_nn;
    logic [17:0] q_n;
    logic        q_drv_n;

    sram_pipe_top #(.LANES(4), .ADDR_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .addr(adr), .din(din), .ce_n(ce_n),
        .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .oe_n(oe_n), .q(q), .q_drv(q_drv)
    );

    sram_pipe_top #(.LANES(2), .ADDR_W(5)) dut_n (
        .clk(clk), .rst_n(rst_n), .addr(adr_n), .din(din_n), .ce_n(ce_nn),
        .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_nn), .bwe_n(bwe_nn), .bw_n(bw_nn),
        .oe_n(oe_n), .q(q_n), .q_drv(q_drv_n)
    );

    function automatic logic [35:0] l4(input logic [8:0] d, c, b, a);
        return {d, c, b, a};
    endfunction

    typedef struct packed {
        logic        sel;
        logic        gwn;
        logic        bwen;
        logic [3:0]  bwn;
        logic [4:0]  a;
        logic [35:0] d;
        logic        edrv;
        logic [35:0] eq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        // R2: global write
        '{1'b1, 1'b0, 1'b1, 4'hF, 5'd3, l4(9'h104, 9'h103, 9'h102, 9'h101), 1'b0, 36'h0},
        // R3/R12: all four lanes through the gate, parity bits set
        '{1'b1, 1'b1, 1'b0, 4'h0, 5'd4, l4(9'h1FF, 9'h1FE, 9'h1FD, 9'h1FC), 1'b0, 36'h0},
        // R1: read
        '{1'b1, 1'b1, 1'b1, 4'hF, 5'd3, 36'h0, 1'b1, l4(9'h104, 9'h103, 9'h102, 9'h101)},
        // R3: lanes a and c only
        '{1'b1, 1'b1, 1'b0, 4'b1010, 5'd3, l4(9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD), 1'b0, 36'h0},
        // R10: read right after write
        '{1'b1, 1'b1, 1'b1, 4'hF, 5'd3, 36'h0, 1'b1, l4(9'h104, 9'h0BB, 9'h102, 9'h0DD)},
        // R2: global overrides disabled lanes
        '{1'b1, 1'b0, 1'b1, 4'hF, 5'd4, l4(9'h011, 9'h022, 9'h033, 9'h044), 1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b1, 4'hF, 5'd4, 36'h0, 1'b1, l4(9'h011, 9'h022, 9'h033, 9'h044)},
        // R4: lane enables low but gate high -> read
        '{1'b1, 1'b1, 1'b1, 4'h0, 5'd3, 36'hF_FFFF_FFFF, 1'b1, l4(9'h104, 9'h0BB, 9'h102, 9'h0DD)},
        // R7: deselected global write ignored
        '{1'b0, 1'b0, 1'b1, 4'hF, 5'd3, 36'h0, 1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b1, 4'hF, 5'd3, 36'h0, 1'b1, l4(9'h104, 9'h0BB, 9'h102, 9'h0DD)},
        // R3: lane d only
        '{1'b1, 1'b1, 1'b0, 4'b0111, 5'd4, l4(9'h1EE, 9'h000, 9'h000, 9'h000), 1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b1, 4'hF, 5'd4, 36'h0, 1'b1, l4(9'h1EE, 9'h022, 9'h033, 9'h044)},
        '{1'b0, 1'b1, 1'b1, 4'hF, 5'd0, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b1, 4'hF, 5'd0, 36'h0, 1'b0, 36'h0}
    };

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic adrv, input logic [35:0] aq,
                       input logic edrv, input logic [35:0] eq);
        n_chk++;
        if (adrv !== edrv || (edrv && aq !== eq)) begin
            n_bad++;
            $display("FAIL %s: drv=%b q=%h expected drv=%b q=%h", tag, adrv, aq, edrv, eq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic sel, input logic gwn, input logic bwen,
                         input logic [3:0] bwn, input logic [4:0] a, input logic [35:0] d);
        ce_n  = !sel;
        ce2   = 1'b1;
        ce2_n = 1'b0;
        gw_n  = gwn;
        bwe_n = bwen;
        bw_n  = bwn;
        adr   = a;
        din   = d;
    endtask

    task automatic idle();
        drive(1'b0, 1'b1, 1'b1, 4'hF, 5'd0, 36'h0);
    endtask

    logic [35:0] ref_m [32];
    logic        edrv_h [64];
    logic [35:0] eq_h [64];
    logic [15:0] lf;

    localparam logic [35:0] XW = 36'h9_1234_5ABC;

    initial begin
        rst_n = 1'b0;
        oe_n  = 1'b0;
        adr_n = 5'd0; din_n = 18'h0; ce_nn = 1'b1; gw_nn = 1'b1; bwe_nn = 1'b1; bw_nn = 2'b11;
        drive(1'b1, 1'b1, 1'b1, 4'hF, 5'd0, 36'h0);
        repeat (3) tick();
        chk("R11 quiet in reset", q_drv, q, 1'b0, 36'h0);
        rst_n = 1'b1;
        idle();
        tick();
        chk("R11 quiet after release", q_drv, q, 1'b0, 36'h0);
        tick();
        chk("R11 quiet after release 2", q_drv, q, 1'b0, 36'h0);

        // Vector table: check of vector i-2 after the edge of vector i
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].sel, VT[i].gwn, VT[i].bwen, VT[i].bwn, VT[i].a, VT[i].d);
            tick();
            if (i >= 2) begin
                chk($sformatf("table vec %0d (R1 R2 R3 R4 R7 R10 R12)", i - 2),
                    q_drv, q, VT[i-2].edrv, VT[i-2].eq);
            end
        end

        // R6: asynchronous output enable
        drive(1'b1, 1'b0, 1'b1, 4'hF, 5'd9, XW); tick();
        drive(1'b1, 1'b1, 1'b1, 4'hF, 5'd9, 36'h0); tick();
        idle(); tick(); tick();
        oe_n = 1'b1; #1;
        chk("R6 oe high blanks output", q_drv, q, 1'b0, 36'h0);
        oe_n = 1'b0; #1;
        chk("R6 oe low restores word", q_drv, q, 1'b1, XW);

        // R8: read followed by a deselect (with global write asserted)
        drive(1'b1, 1'b1, 1'b1, 4'hF, 5'd9, 36'h0); tick();
        drive(1'b0, 1'b0, 1'b1, 4'hF, 5'd9, 36'h0); tick();
        idle(); tick();
        chk("R8 read before deselect returns data", q_drv, q, 1'b1, XW);
        tick();
        chk("R8 deselect reaches output", q_drv, q, 1'b0, 36'h0);

        // R9: write slot is quiet
        drive(1'b1, 1'b0, 1'b1, 4'hF, 5'd10, 36'h1); tick();
        idle(); tick(); tick();
        chk("R9 write slot not driven", q_drv, q, 1'b0, 36'h0);

        // R7: each enable wrong in turn
        for (int e = 0; e < 3; e++) begin
            drive(1'b1, 1'b0, 1'b1, 4'hF, 5'd9, 36'h0);
            if (e == 0) ce_n = 1'b1;
            if (e == 1) ce2 = 1'b0;
            if (e == 2) ce2_n = 1'b1;
            tick();
            drive(1'b1, 1'b1, 1'b1, 4'hF, 5'd9, 36'h0); tick();
            idle(); tick(); tick();
            chk($sformatf("R7 write ignored enable %0d", e), q_drv, q, 1'b1, XW);
            drive(1'b1, 1'b1, 1'b1, 4'hF, 5'd9, 36'h0);
            if (e == 0) ce_n = 1'b1;
            if (e == 1) ce2 = 1'b0;
            if (e == 2) ce2_n = 1'b1;
            tick();
            idle(); tick(); tick();
            chk($sformatf("R7 read ignored enable %0d", e), q_drv, q, 1'b0, 36'h0);
        end

        // R5: narrow build, global write then lane b only
        ce_nn = 1'b0; gw_nn = 1'b0; adr_n = 5'd7; din_n = {9'h155, 9'h0AA}; tick();
        gw_nn = 1'b1; bwe_nn = 1'b0; bw_nn = 2'b01; din_n = {9'h1F0, 9'h00F}; tick();
        bwe_nn = 1'b1; bw_nn = 2'b11; tick();
        ce_nn = 1'b1; tick(); tick();
        chk("R5 narrow lane b merge", q_drv_n, {18'h0, q_n}, 1'b1, {18'h0, 9'h1F0, 9'h0AA});

        // Reference model run: R1 R2 R3 R10
        for (int a = 0; a < 8; a++) begin
            ref_m[a] = {a[3:0], 16'hC3A5 ^ 16'(a), 16'h3C00 + 16'(a)};
            drive(1'b1, 1'b0, 1'b1, 4'hF, 5'(a), ref_m[a]);
            tick();
        end
        idle(); tick(); tick();
        lf = 16'hACE1;
        for (int k = 0; k < 62; k++) begin
            logic [4:0]  a;
            logic [35:0] d;
            logic [3:0]  bwn;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a   = {2'b00, lf[10:8]};
            d   = {lf[7:4], lf, lf ^ 16'h5A5A};
            bwn = lf[5:2];
            edrv_h[k] = 1'b0;
            eq_h[k]   = 36'h0;
            if (k >= 60) begin
                idle();
            end else begin
                case (lf[1:0])
                    2'd0: begin
                        drive(1'b1, 1'b1, 1'b1, 4'hF, a, d);
                        edrv_h[k] = 1'b1; eq_h[k] = ref_m[a];
                    end
                    2'd1: begin
                        drive(1'b1, 1'b0, 1'b1, bwn, a, d);
                        ref_m[a] = d;
                    end
                    2'd2: begin
                        drive(1'b1, 1'b1, 1'b0, bwn, a, d);
                        if (bwn == 4'hF) begin
                            edrv_h[k] = 1'b1; eq_h[k] = ref_m[a];
                        end else begin
                            for (int l = 0; l < 4; l++) begin
                                if (!bwn[l]) ref_m[a][l*9 +: 9] = d[l*9 +: 9];
                            end
                        end
                    end
                    default: drive(1'b0, 1'b0, 1'b0, 4'h0, a, d);
                endcase
            end
            tick();
            if (k >= 2) begin
                chk($sformatf("model cycle %0d (R1 R2 R3 R10)", k - 2),
                    q_drv, q, edrv_h[k-2], eq_h[k-2]);
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule